// File: doc/BRIEF.md
# Register Scoreboard Stall Unit

This block finds data hazards for an in-order pipeline. It keeps one ready flag for each architectural register. When an instruction leaves decode with a destination, the flag for that destination drops. The flag rises again when the result for that register is written back. The instruction that is currently in decode names up to `NUM_SRC` source registers and one destination, and each has a use flag. If any register it uses is not ready, the unit raises `stall` combinationally in the same cycle. The consumer therefore waits until the value it needs has been produced.

The destination flag is checked as well as the sources. As a result, a second writer to a register that is still in flight is held back, so two writes to one register cannot complete in the wrong order. Register 0 is a constant and always reads as ready. A flush input marks every register ready in one step. The unit contains no forwarding and no renaming, and it is not part of the pipeline registers.

Top module: `reg_scoreboard`

## Requirements
- R1: Reset (active-low `rst_n`) marks every register ready, so no combination of operands stalls after reset.
- R2: An accepted issue (`issue` high, `stall` low, `dec_dst_use` high) clears the ready flag of `dec_dst_idx` at that clock edge, and readers of that register stall from the next cycle on.
- R3: `stall` is high in the same cycle whenever any source slot whose use flag is high names a register that is not ready. Slot k occupies bits [k*IDX_W +: IDX_W] of `dec_src_idx`.
- R4: `stall` is high when `dec_dst_use` is high and the destination register is not ready, which blocks a second in-flight writer.
- R5: A write-back (`wb_valid` high) sets the ready flag of `wb_idx` at that edge, and dependent instructions proceed from the next cycle.
- R6: Register 0 is always ready. An issue that targets it never causes a stall.
- R7: When an accepted issue and a write-back name the same register in the same cycle, the clear wins and the register ends not ready.
- R8: `flush` marks all registers ready at the next edge and overrides a clear from an issue in the same cycle.
- R9: An `issue` strobe while `stall` is high changes no ready flag.
- R10: Source or destination indices whose use flag is low are ignored by the stall check.
- R11: An accepted issue with `dec_dst_use` low clears no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Mark every register ready |
| dec_src_idx | input | NUM_SRC*IDX_W | Packed source register indices of the decoding instruction |
| dec_src_use | input | NUM_SRC | Use flag for each source slot |
| dec_dst_idx | input | IDX_W | Destination register index of the decoding instruction |
| dec_dst_use | input | 1 | Decoding instruction writes a register |
| issue | input | 1 | Decoding instruction leaves decode this cycle |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_idx | input | IDX_W | Register index of the write-back |
| stall | output | 1 | Hold the decoding instruction |

## Verification
The hardest case to reach is a write-back and an accepted issue that name the same register in one cycle. An accepted issue needs its destination to be ready, so in normal operation nothing is in flight for that register. The stimulus therefore drives a write-back to a register that is already ready while an instruction issues to it, and then reads that register to show that it is left busy. A second hard case is an `issue` strobe during a stall. Here the bench raises issue together with a blocking source, and later reads the would-be destination to show that its flag never dropped.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // next-state action for one ready flag
   typedef enum logic [1:0] {
      FLAG_HOLD  = 2'd0,
      FLAG_SET   = 2'd1,
      FLAG_CLEAR = 2'd2,
      FLAG_ALL   = 2'd3
   } flag_act_e;

   function automatic flag_act_e pick_action(input logic flush_i,
                                             input logic clr_hit,
                                             input logic set_hit);
      if (flush_i)      return FLAG_ALL;
      else if (clr_hit) return FLAG_CLEAR;
      else if (set_hit) return FLAG_SET;
      else              return FLAG_HOLD;
   endfunction
endpackage

// File: rtl/sb_flags.sv
module sb_flags
   import sb_pkg::*;
#(
   parameter int NUM_REGS       = 32,
   parameter bit ZERO_HARDWIRED = 1'b1,
   localparam int IDX_W         = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   input  logic                set_en,
   input  logic [IDX_W-1:0]    set_idx,
   output logic [NUM_REGS-1:0] ready_q
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_flag
      if (i == 0 && ZERO_HARDWIRED) begin : g_const
         assign ready_q[i] = 1'b1;
      end else begin : g_reg
         logic      clr_hit, set_hit;
         flag_act_e act;

         assign clr_hit = clr_en && (clr_idx == IDX_W'(i));
         assign set_hit = set_en && (set_idx == IDX_W'(i));
         assign act     = pick_action(flush, clr_hit, set_hit);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ready_q[i] <= 1'b1;
            end else begin
               case (act)
                  FLAG_ALL, FLAG_SET: ready_q[i] <= 1'b1;
                  FLAG_CLEAR:         ready_q[i] <= 1'b0;
                  default:            ready_q[i] <= ready_q[i];
               endcase
            end
         end

         // R7: clear wins over a same-cycle set
         assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_idx == IDX_W'(i) && !flush) |=> !ready_q[i]);
         assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_idx == IDX_W'(i) && !(clr_en && clr_idx == IDX_W'(i)))
            |=> ready_q[i]);
      end
   end

   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (&ready_q));

endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
   parameter int NUM_REGS  = 32,
   parameter int NUM_PORTS = 3,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0]        ready,
   input  logic [NUM_PORTS*IDX_W-1:0] idx,
   input  logic [NUM_PORTS-1:0]       use_en,
   output logic                       any_busy
);

   logic [NUM_PORTS-1:0] busy;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [IDX_W-1:0] sel;
      assign sel     = idx[p*IDX_W +: IDX_W];
      assign busy[p] = use_en[p] && !ready[sel];
   end

   assign any_busy = |busy;

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
   parameter int NUM_REGS       = 32,
   parameter int NUM_SRC        = 2,
   parameter bit ZERO_HARDWIRED = 1'b1,
   localparam int IDX_W         = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [NUM_SRC*IDX_W-1:0] dec_src_idx,
   input  logic [NUM_SRC-1:0]       dec_src_use,
   input  logic [IDX_W-1:0]         dec_dst_idx,
   input  logic                     dec_dst_use,
   input  logic                     issue,
   input  logic                     wb_valid,
   input  logic [IDX_W-1:0]         wb_idx,
   output logic                     stall
);

   localparam int NUM_CHK = NUM_SRC + 1;

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("reg_scoreboard: NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("reg_scoreboard: NUM_SRC must be at least 1");
   end

   logic [NUM_REGS-1:0]      ready_q;
   logic [NUM_CHK*IDX_W-1:0] chk_idx;
   logic [NUM_CHK-1:0]       chk_use;
   logic                     accept;
   logic                     clr_en;

   assign chk_idx = {dec_dst_idx, dec_src_idx};
   assign chk_use = {dec_dst_use, dec_src_use};

   sb_lookup #(
      .NUM_REGS  (NUM_REGS),
      .NUM_PORTS (NUM_CHK)
   ) u_lookup (
      .ready    (ready_q),
      .idx      (chk_idx),
      .use_en   (chk_use),
      .any_busy (stall)
   );

   assign accept = issue && !stall;
   assign clr_en = accept && dec_dst_use;

   sb_flags #(
      .NUM_REGS       (NUM_REGS),
      .ZERO_HARDWIRED (ZERO_HARDWIRED)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .clr_en  (clr_en),
      .clr_idx (dec_dst_idx),
      .set_en  (wb_valid),
      .set_idx (wb_idx),
      .ready_q (ready_q)
   );

   assert_stalled_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && stall && !wb_valid && !flush) |=> $stable(ready_q));

   assert_no_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !dec_dst_use && !wb_valid && !flush) |=> $stable(ready_q));

endmodule

// File: tb/sim_reg_scoreboard.sv
module sim_reg_scoreboard;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 32;
   localparam int IW = 5;

   typedef struct packed {
      logic [4:0] s0; logic s0v;
      logic [4:0] s1; logic s1v;
      logic [4:0] d;  logic dv;
      logic iss; logic wbv; logic [4:0] wbi; logic fl;
      logic exp; logic [3:0] req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{5'd1, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd1},  // R1
      '{5'd1, 1'b1, 5'd2, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd2},  // R2 issue r5
      '{5'd5, 1'b1, 5'd0, 1'b0, 5'd6, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 4'd3},  // R3 slot0, R9 issue ignored
      '{5'd0, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 4'd3},  // R3 slot1
      '{5'd6, 1'b1, 5'd0, 1'b0, 5'd7, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd9},  // R9 r6 still ready
      '{5'd5, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 4'd4},  // R4 WAW
      '{5'd5, 1'b0, 5'd5, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd10}, // R10 unused slots
      '{5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd5, 1'b0, 1'b1, 4'd5},  // R5 wb, still busy now
      '{5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd5},  // R5 ready next cycle
      '{5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd6},  // R6 issue to r0
      '{5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd6},  // R6 r0 ready
      '{5'd1, 1'b1, 5'd0, 1'b0, 5'd9, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd11}, // R11 no dst use
      '{5'd9, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd11}, // R11 r9 ready
      '{5'd0, 1'b0, 5'd0, 1'b0, 5'd10, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd2}, // R2 issue r10
      '{5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 4'd2}, // R2 r10 busy
      '{5'd0, 1'b0, 5'd0, 1'b0, 5'd11, 1'b1, 1'b1, 1'b1, 5'd11, 1'b0, 1'b0, 4'd7}, // R7 issue+wb r11
      '{5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 4'd7}, // R7 clear won
      '{5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd2}, // R2 issue r12
      '{5'd0, 1'b0, 5'd0, 1'b0, 5'd13, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 4'd8}, // R8 flush + issue r13
      '{5'd10, 1'b1, 5'd11, 1'b1, 5'd13, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd8}, // R8 all ready
      '{5'd12, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd8}  // R8 r12 ready
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [2*IW-1:0] dec_src_idx = '0;
   logic [1:0] dec_src_use = '0;
   logic [IW-1:0] dec_dst_idx = '0;
   logic dec_dst_use = 1'b0;
   logic issue = 1'b0;
   logic wb_valid = 1'b0;
   logic [IW-1:0] wb_idx = '0;
   logic stall;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reg_scoreboard #(.NUM_REGS(NREG), .NUM_SRC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
      .dec_dst_idx(dec_dst_idx), .dec_dst_use(dec_dst_use),
      .issue(issue), .wb_valid(wb_valid), .wb_idx(wb_idx),
      .stall(stall)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      dec_src_idx = {v.s1, v.s0};
      dec_src_use = {v.s1v, v.s0v};
      dec_dst_idx = v.d;
      dec_dst_use = v.dv;
      issue       = v.iss;
      wb_valid    = v.wbv;
      wb_idx      = v.wbi;
      flush       = v.fl;
   endtask

   task automatic check_stall(input logic exp, input int req, input string what);
      #2;
      checks++;
      if (stall !== exp) begin
         errors++;
         $display("FAIL R%0d %s: stall=%b expected=%b", req, what, stall, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_stall(1'b0, 1, "idle after reset");
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check_stall(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
      end
      // R1 directed: a busy register becomes ready again through reset
      apply('{5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd1});
      apply('{5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 4'd1});
      check_stall(1'b1, 2, "r3 busy before reset");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_stall(1'b0, 1, "r3 ready after reset");
      // R10 directed: busy register named only by unused destination slot
      apply('{5'd0, 1'b0, 5'd0, 1'b0, 5'd14, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 4'd10});
      apply('{5'd14, 1'b0, 5'd14, 1'b0, 5'd14, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 4'd10});
      check_stall(1'b0, 10, "r14 named with use flags low");
      finish_run();
   end

   initial begin
      repeat (2000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end
endmodule